// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timer

This block paces the bus cycles of one bank of an 8-bit or 16-bit NAND flash that sits on a static memory bus. Before it issues accesses, the host loads two configuration words. The control word holds the bank enable, the device width, the wait-input enable and two 4-bit read turnaround delays. The timing word holds four 8-bit cycle counts.

The host then issues accesses through a valid/ready handshake. Each access goes to one of three windows: command, address or data. Each access is a single byte or a 32-bit word. A word access is split into several device bus cycles. The block steps each bus cycle through a setup phase, a strobe phase and a hold phase. It drives the latch enables, the write and read strobes and the data output enable to suit the window. Before the cycle starts it inserts an idle gap when the previous access calls for one. The handshake completes in the last hold cycle of the last bus cycle. For reads, the assembled data is valid in that same cycle.

Top module: `nand_strobe_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale, nand_dq_oe and acc_ready are low, and every configuration field is zero.
- R2: Writing the control word (cfg_sel=0) loads these fields. Bit 1 enables the wait input. Bit 2 is the bank enable. Bit 4 selects 16-bit width. Bits 12:9 hold the command-to-read delay and bits 16:13 hold the address-to-read delay. nand_ce_n is the inverse of bit 2. No access is accepted while bit 2 is 0, and no strobe moves during that time.
- R3: Writing the timing word (cfg_sel=1) loads four counts: setup in bits 7:0, strobe in bits 15:8, hold in bits 23:16 and turnaround in bits 31:24. Each bus cycle lasts setup cycles, then strobe+1 cycles with the strobe low, then hold cycles. acc_ready is high for exactly one cycle, the last hold cycle of the last bus cycle.
- R4: A setup or hold count of zero is treated as one cycle.
- R5: Window code 1 is the command window, and nand_cle is high through the setup, strobe and hold phases of its cycles. Window code 2 is the address window, with nand_ale high in the same way. Codes 0 and 3 are the data window, which raises neither signal.
- R6: A byte access (acc_word=0) makes one bus cycle. A word access makes two 16-bit cycles on the data window in 16-bit mode and four 8-bit cycles in every other case, least significant lane first. In 8-bit cycles, nand_dq_o[15:8] is zero.
- R7: A write drives nand_dq_oe high through the setup, strobe and hold phases and pulses nand_we_n. A read keeps nand_dq_oe low and pulses nand_re_n.
- R8: Read data is sampled from nand_dq_i in the last strobe cycle of each bus cycle. It is placed into acc_rdata least significant lane first, and the unused upper bits are zero.
- R9: A data-window read that follows a command-window access waits the command-to-read delay in idle cycles before its first setup phase. One that follows an address-window access waits the address-to-read delay. No strobe, latch enable or output enable is active during the wait.
- R10: A write that follows a read waits the turnaround count in idle cycles with nand_dq_oe low before its first setup phase. This gap takes priority over R9.
- R11: With the wait input enabled, a low nand_wait_n in the last strobe cycle extends the strobe phase. With the wait input disabled, nand_wait_n has no effect.
- R12: nand_we_n and nand_re_n are never low together, nand_cle and nand_ale are never high together, and no strobe falls while nand_ce_n is high.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the timing word |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access request; held with its fields until acc_ready |
| acc_ready | output | 1 | Access complete, handshake point |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_win | input | 2 | Window: 1 command, 2 address, 0 or 3 data |
| acc_word | input | 1 | 1 for a 32-bit access, 0 for a single lane |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Assembled read data, valid with acc_ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 16 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 16 | Data bus input |
| nand_wait_n | input | 1 | Device wait input, active low |

## Verification
The strobe extension from the wait input and the read data capture can both fall on the same last strobe cycle. The bench holds nand_wait_n low on the first read strobe cycle and drives the inverted pattern on nand_dq_i for as long as it holds wait low. It then releases wait and puts the true pattern on the bus in the same cycle. The capture is judged correct only if acc_rdata carries the true pattern and the strobe lasted the extended length. The same stimulus with the wait input disabled must instead capture the inverted value after a single strobe cycle.

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
  parameter int CW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        acc_valid,
  output logic        acc_ready,
  input  logic        acc_write,
  input  logic [1:0]  acc_win,
  input  logic        acc_word,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [15:0] nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [15:0] nand_dq_i,
  input  logic        nand_wait_n
);
  localparam int NW = CW + 1;
  localparam logic [NW-1:0] ONE = NW'(1);

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_SETUP, ST_STROBE, ST_HOLD} st_t;

  logic          bank_en, wide, wait_en;
  logic [3:0]    dly_cmd, dly_adr;
  logic [CW-1:0] t_set, t_str, t_hold, t_hiz;

  st_t           st;
  logic [NW-1:0] cnt;
  logic [1:0]    beat, last_beat, win_q, prev_win;
  logic          wr_q, lane16, prev_rd;
  logic [31:0]   wdata_q;

  logic [NW-1:0] set_n, str_n, hold_n, gap_n;
  logic          busy_ph, last_cyc, stall, req_data;

  assign req_data = !(acc_win == 2'd1 || acc_win == 2'd2);
  assign set_n    = (t_set == '0) ? ONE : NW'(t_set);
  assign hold_n   = (t_hold == '0) ? ONE : NW'(t_hold);
  assign str_n    = NW'(t_str) + ONE;
  assign last_cyc = (cnt == ONE);
  assign stall    = wait_en && !nand_wait_n;
  assign busy_ph  = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);

  assign nand_ce_n  = !bank_en;
  assign nand_cle   = busy_ph && (win_q == 2'd1);
  assign nand_ale   = busy_ph && (win_q == 2'd2);
  assign nand_we_n  = !((st == ST_STROBE) && wr_q);
  assign nand_re_n  = !((st == ST_STROBE) && !wr_q);
  assign nand_dq_oe = busy_ph && wr_q;
  assign acc_ready  = (st == ST_HOLD) && last_cyc && (beat == last_beat);

  always_comb begin
    gap_n = '0;
    if (acc_write && prev_rd)
      gap_n = NW'(t_hiz);
    else if (!acc_write && req_data && prev_win == 2'd1)
      gap_n = NW'(dly_cmd);
    else if (!acc_write && req_data && prev_win == 2'd2)
      gap_n = NW'(dly_adr);
  end

  always_comb begin
    if (lane16)
      nand_dq_o = beat[0] ? wdata_q[31:16] : wdata_q[15:0];
    else begin
      case (beat)
        2'd0:    nand_dq_o = {8'h00, wdata_q[7:0]};
        2'd1:    nand_dq_o = {8'h00, wdata_q[15:8]};
        2'd2:    nand_dq_o = {8'h00, wdata_q[23:16]};
        default: nand_dq_o = {8'h00, wdata_q[31:24]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en <= 1'b0; wide <= 1'b0; wait_en <= 1'b0;
      dly_cmd <= '0; dly_adr <= '0;
      t_set <= '0; t_str <= '0; t_hold <= '0; t_hiz <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        wait_en <= cfg_wdata[1];
        bank_en <= cfg_wdata[2];
        wide    <= cfg_wdata[4];
        dly_cmd <= cfg_wdata[12:9];
        dly_adr <= cfg_wdata[16:13];
      end else begin
        t_set  <= cfg_wdata[CW-1:0];
        t_str  <= cfg_wdata[8 +: CW];
        t_hold <= cfg_wdata[16 +: CW];
        t_hiz  <= cfg_wdata[24 +: CW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; beat <= '0; last_beat <= '0;
      win_q <= '0; wr_q <= 1'b0; lane16 <= 1'b0; wdata_q <= '0;
      prev_rd <= 1'b0; prev_win <= '0; acc_rdata <= '0;
    end else begin
      case (st)
        ST_IDLE: if (acc_valid && bank_en) begin
          win_q     <= acc_win;
          wr_q      <= acc_write;
          wdata_q   <= acc_wdata;
          lane16    <= wide && req_data;
          beat      <= '0;
          last_beat <= acc_word ? ((wide && req_data) ? 2'd1 : 2'd3) : 2'd0;
          acc_rdata <= '0;
          if (gap_n != '0) begin st <= ST_GAP;   cnt <= gap_n; end
          else             begin st <= ST_SETUP; cnt <= set_n; end
        end
        ST_GAP: if (last_cyc) begin st <= ST_SETUP; cnt <= set_n; end
                else cnt <= cnt - ONE;
        ST_SETUP: if (last_cyc) begin st <= ST_STROBE; cnt <= str_n; end
                  else cnt <= cnt - ONE;
        ST_STROBE: begin
          if (last_cyc && !stall) begin
            if (!wr_q) begin
              if (lane16) begin
                for (int i = 0; i < 2; i++)
                  if (beat == 2'(i)) acc_rdata[i*16 +: 16] <= nand_dq_i;
              end else begin
                for (int i = 0; i < 4; i++)
                  if (beat == 2'(i)) acc_rdata[i*8 +: 8] <= nand_dq_i[7:0];
              end
            end
            st  <= ST_HOLD;
            cnt <= hold_n;
          end else if (!last_cyc) cnt <= cnt - ONE;
        end
        ST_HOLD: if (last_cyc) begin
          if (beat == last_beat) begin
            st       <= ST_IDLE;
            prev_rd  <= !wr_q;
            prev_win <= win_q;
          end else begin
            beat <= beat + 2'd1;
            st   <= ST_SETUP;
            cnt  <= set_n;
          end
        end else cnt <= cnt - ONE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_strobe_timer_chk.sv
module nand_strobe_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_ready,
  input logic [1:0] acc_win,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_dq_oe
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  // R12
  ce_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  // R7
  read_undriven_chk: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_dq_oe);
  // R3
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ready |=> !acc_ready);
  // R5
  data_win_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_win == 2'd0) |-> (!nand_cle && !nand_ale));
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe && !acc_ready));
endmodule

bind nand_strobe_timer nand_strobe_timer_chk chk (.*);

// File: tb/tb_nand_strobe_timer.sv
`timescale 1ns/1ps
module tb_nand_strobe_timer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cfg_we, cfg_sel, acc_valid, acc_ready, acc_write, acc_word;
  logic [31:0] cfg_wdata, acc_wdata, acc_rdata;
  logic [1:0] acc_win;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_wait_n;
  logic [15:0] nand_dq_o, nand_dq_i;

  nand_strobe_timer dut (.*);

  int n_chk = 0, n_fail = 0;
  int ts, tw, th, tz, tcl, tal;
  bit wide, wen, en;
  bit prev_rd = 0;
  logic [1:0] prev_win = 0;
  int m_lat, m_stb, m_cle, m_ale, m_oe, m_lead, m_oelead, m_werr, m_excl;
  logic [31:0] m_rd;
  bit m_to;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int k, logic [15:0] salt);
    return salt ^ 16'(k * 16'h3B1D) ^ 16'h5A0F;
  endfunction

  function automatic logic [15:0] exp_w(logic [31:0] wd, int b, bit l16);
    if (l16) return (b == 1) ? wd[31:16] : wd[15:0];
    return {8'h00, wd[b*8 +: 8]};
  endfunction

  function automatic logic [31:0] exp_rd(int nb, bit l16, logic [15:0] salt, bit inv);
    logic [31:0] r = '0;
    for (int k = 0; k < nb; k++) begin
      logic [15:0] p = inv ? ~pat(k, salt) : pat(k, salt);
      if (l16) r[k*16 +: 16] = p; else r[k*8 +: 8] = p[7:0];
    end
    return r;
  endfunction

  task automatic set_cfg();
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0;
    cfg_wdata = (32'(wen) << 1) | (32'(en) << 2) | (32'd1 << 3) | (32'(wide) << 4)
              | (32'(tcl) << 9) | (32'(tal) << 13);
    @(negedge clk);
    cfg_sel = 1;
    cfg_wdata = 32'(ts) | (32'(tw) << 8) | (32'(th) << 16) | (32'(tz) << 24);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(logic [1:0] win, bit wr, bit word, logic [31:0] wd,
                     logic [15:0] salt, int stall);
    bit seen = 0, seen_oe = 0, prev_stb = 0, done = 0, l16;
    int wb = -1, rb = -1, left = 0;
    l16 = wide && (win == 0 || win == 3);
    m_lat = 0; m_stb = 0; m_cle = 0; m_ale = 0; m_oe = 0; m_lead = 0;
    m_oelead = 0; m_werr = 0; m_excl = 0; m_to = 0; m_rd = '0;
    @(negedge clk);
    acc_win = win; acc_write = wr; acc_word = word; acc_wdata = wd; acc_valid = 1;
    for (int k = 0; k < 3000 && !done; k++) begin
      bit stb;
      @(negedge clk);
      m_lat++;
      stb = !nand_we_n || !nand_re_n;
      if (!seen && !stb) m_lead++;
      if (stb) seen = 1;
      if (!seen_oe && !nand_dq_oe) m_oelead++;
      if (nand_dq_oe) begin seen_oe = 1; m_oe++; end
      if (nand_cle) m_cle++;
      if (nand_ale) m_ale++;
      if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale)) m_excl++;
      if (!nand_we_n) begin
        m_stb++;
        if (!prev_stb) wb++;
        if (!nand_dq_oe || nand_dq_o !== exp_w(wd, wb, l16)) m_werr++;
      end
      if (!nand_re_n) begin
        m_stb++;
        if (!prev_stb) begin
          rb++;
          if (stall > 0) begin nand_wait_n = 0; nand_dq_i = ~pat(rb, salt); left = stall; end
          else nand_dq_i = pat(rb, salt);
        end else if (left > 0) begin
          left--;
          if (left == 0) begin nand_wait_n = 1; nand_dq_i = pat(rb, salt); end
        end
      end
      prev_stb = stb;
      if (acc_ready) begin m_rd = acc_rdata; done = 1; end
    end
    if (!done) m_to = 1;
    @(negedge clk);
    acc_valid = 0;
    nand_wait_n = 1;
  endtask

  task automatic access(logic [1:0] win, bit wr, bit word, logic [31:0] wd, int stall);
    logic [15:0] salt = 16'($urandom);
    bit isd = (win == 0 || win == 3);
    bit l16 = wide && isd;
    int nb = word ? (l16 ? 2 : 4) : 1;
    int s = (ts == 0) ? 1 : ts;
    int h = (th == 0) ? 1 : th;
    bit ext = (stall > 0) && wen && !wr;
    int w = ext ? stall + 1 : tw + 1;
    int per = s + w + h;
    int g = 0;
    if (wr && prev_rd) g = tz;
    else if (!wr && isd && prev_win == 1) g = tcl;
    else if (!wr && isd && prev_win == 2) g = tal;
    run(win, wr, word, wd, salt, stall);
    chk(!m_to, "R3 completion", m_to, 0);
    chk(m_lat == g + nb * per, "R3 latency", m_lat, g + nb * per);
    chk(m_stb == nb * w, ext ? "R11 strobe width" : "R6 strobe cycles", m_stb, nb * w);
    chk(m_lead == g + s, (g > 0 && !wr) ? "R9 delay before strobe" : "R4 setup lead", m_lead, g + s);
    chk(m_cle == ((win == 1) ? nb * per : 0), "R5 CLE cycles", m_cle, (win == 1) ? nb * per : 0);
    chk(m_ale == ((win == 2) ? nb * per : 0), "R5 ALE cycles", m_ale, (win == 2) ? nb * per : 0);
    chk(m_excl == 0, "R12 exclusivity", m_excl, 0);
    if (wr) begin
      chk(m_werr == 0, "R6 write lanes", m_werr, 0);
      chk(m_oe == nb * per, "R7 output enable", m_oe, nb * per);
      chk(m_oelead == g, "R10 turnaround", m_oelead, g);
    end else begin
      logic [31:0] e = exp_rd(nb, l16, salt, (stall > 0) && !wen);
      chk(m_oe == 0, "R7 read undriven", m_oe, 0);
      chk(m_rd == e, "R8 read data", m_rd, e);
    end
    prev_rd = !wr;
    prev_win = win;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; acc_valid = 0; acc_write = 0;
    acc_word = 0; acc_win = 0; acc_wdata = 0; nand_dq_i = 0; nand_wait_n = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !acc_ready,
        "R1 reset state", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, acc_ready}, 7'b1110000);

    // R2: bank disabled stalls the access
    en = 0; ts = 2; tw = 1; th = 1; tz = 2; tcl = 3; tal = 5; wide = 0; wen = 0;
    set_cfg();
    acc_win = 1; acc_write = 1; acc_word = 0; acc_wdata = 32'h70; acc_valid = 1;
    begin
      int moved = 0;
      repeat (10) begin
        @(negedge clk);
        if (acc_ready || !nand_we_n || !nand_re_n || nand_cle || !nand_ce_n) moved++;
      end
      chk(moved == 0, "R2 disabled bank idle", moved, 0);
    end
    @(negedge clk); acc_valid = 0;
    en = 1; set_cfg();
    @(negedge clk);
    chk(!nand_ce_n, "R2 chip enable", nand_ce_n, 0);

    access(2'd1, 1, 0, 32'h0000_0000, 0);          // R5 command
    access(2'd2, 1, 1, 32'h0403_0201, 0);          // R6 four address cycles
    access(2'd0, 0, 1, 0, 0);                      // R9 address-to-read delay
    access(2'd0, 1, 1, 32'hCAFE_F00D, 0);          // R10 turnaround
    access(2'd1, 1, 0, 32'h30, 0);
    access(2'd0, 0, 0, 0, 0);                      // R9 command-to-read delay
    ts = 0; th = 0; set_cfg();
    access(2'd0, 1, 1, 32'h1234_5678, 0);          // R4 zero counts
    wide = 1; ts = 1; th = 2; set_cfg();
    access(2'd0, 1, 1, 32'hA1B2_C3D4, 0);          // R6 16-bit lanes
    access(2'd0, 0, 1, 0, 0);
    access(2'd1, 1, 1, 32'h0055_AA11, 0);          // R6 command stays 8-bit
    wide = 0; wen = 1; tw = 0; set_cfg();
    access(2'd0, 0, 0, 0, 3);                      // R11 wait extends, capture at release
    access(2'd0, 0, 1, 0, 2);
    wen = 0; set_cfg();
    access(2'd0, 0, 0, 0, 3);                      // R11 wait ignored when disabled

    for (int n = 0; n < 150; n++) begin
      if (n % 10 == 0) begin
        ts = $urandom_range(0, 4); tw = $urandom_range(0, 3); th = $urandom_range(0, 3);
        tz = $urandom_range(0, 4); tcl = $urandom_range(0, 6); tal = $urandom_range(0, 6);
        wide = 1'($urandom); wen = 0;
        set_cfg();
      end
      access(2'($urandom), 1'($urandom), 1'($urandom), $urandom, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule